// File: doc/BRIEF.md
# Frame Table Line Sequencer

This block walks the program memory of one output channel. The memory opens with a lookup area holding one start address per frame. Line segments sit directly after that area. While enabled, the sequencer reads the entry of the selected frame. A zero entry leaves it parked on that entry. A non-zero entry makes it jump to that address and fetch lines from there. Each line has a header word and a duration word, followed by a variable number of payload words. The payload words go out in order to a downstream output stage. The sequencer then holds the line active for the programmed time.

Header flags control how lines are gated and chained. One flag makes a line wait for the trigger before it starts. A second flag makes the sequencer wait for the trigger after the line ends. A third flag sends the sequencer back to the lookup area when the line ends. The remaining flags produce a phase-clear pulse and per-line silence and aux indications. The surrounding logic selects a frame, raises enable and drives a trigger level. The downstream stage uses the payload and the line outputs.

Top module: `frame_line_seq`

## Requirements
- R1: While parked at the lookup area, `mem_addr` equals `frame_sel` zero-extended. A non-zero word read there is the address of the first line header of that frame.
- R2: A zero word in the lookup area keeps the sequencer there, with no line and no payload, until `frame_sel` changes to a frame with a non-zero word.
- R3: Line format. Word 0 is the header: bits [3:0] give the payload word count, [5:4] the output type, 6 trigger-before, 7 silence, 8 aux, 9 jump, 10 clear, 11 wait-after and [15:12] the shift. Word 1 is the duration. The payload words follow and each one appears once on `pay_word` with `pay_valid` high and `pay_type` equal to the header type. They appear in memory order and before the line becomes active.
- R4: `line_active` stays high for exactly duration × 2^shift consecutive cycles. A duration of zero gives one cycle.
- R5: A line with trigger-before set does not become active while `trigger` is low. It starts once `trigger` is seen high.
- R6: After a line with wait-after set, the next line does not start until `trigger` is seen high.
- R7: After a line with jump set, the sequencer returns to the lookup area and restarts from the selected frame's entry. Without jump, it fetches the header that directly follows the line.
- R8: `phase_clr` is high for exactly the first active cycle of a line with clear set, and it is never high for other lines.
- R9: `line_aux`, `line_silence` and `line_type` show the header's aux, silence and type only while `line_active` is high. Otherwise they are zero.
- R10: While `enable` is low, there is no line activity and no payload. When `enable` drops, the sequencer is back at the lookup area one cycle later.
- R11: After synchronous reset, all outputs are inactive and `mem_addr` points at the lookup entry of `frame_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Lets the sequencer run; low forces idle at the lookup area |
| frame_sel | input | FRAME_W | Selected frame index |
| trigger | input | 1 | Trigger level for trigger-before and wait-after gating |
| mem_addr | output | ADDR_W | Word address into channel memory |
| mem_rdata | input | 16 | Word read at `mem_addr`, same cycle |
| pay_valid | output | 1 | Payload word strobe |
| pay_word | output | 16 | Payload word |
| pay_type | output | 2 | Output type of the line carrying the payload |
| line_active | output | 1 | High while a line is being timed |
| line_aux | output | 1 | Aux flag of the active line |
| line_silence | output | 1 | Silence flag of the active line |
| line_type | output | 2 | Output type of the active line |
| phase_clr | output | 1 | One-cycle phase-accumulator clear at line start |

## Verification
The hardest state to reach from the ports is a hold after a wait-after line in a frame that does not jump. The next header has already been fetched, so the sequencer has to stop between two lines of the same segment. The bench builds a frame whose first line carries wait-after and whose second line carries jump. It keeps `trigger` low across the whole first line and checks for silence over a long window. It then pulses `trigger` for one cycle and times the second line. The same walk also covers the return through the lookup area, because the frame then repeats.

// File: rtl/fls_pkg.sv
package fls_pkg;

    localparam int WORD_W  = 16;
    localparam int SHIFT_W = 4;
    localparam int LEN_W   = 4;
    localparam int KIND_W  = 2;

    typedef enum logic [2:0] {
        ST_TABLE,
        ST_HEAD,
        ST_DUR,
        ST_DATA,
        ST_ARM,
        ST_RUN,
        ST_HOLD
    } seq_state_e;

    typedef struct packed {
        logic [SHIFT_W-1:0] shift;
        logic               wait_after;
        logic               clear;
        logic               jump;
        logic               aux;
        logic               silence;
        logic               trig_before;
        logic [KIND_W-1:0]  kind;
        logic [LEN_W-1:0]   len;
    } line_hdr_t;

    function automatic line_hdr_t unpack_hdr(input logic [WORD_W-1:0] w);
        return line_hdr_t'(w);
    endfunction

    function automatic logic line_follows(input line_hdr_t h);
        return !h.jump;
    endfunction

endpackage

// File: rtl/fls_timer.sv
module fls_timer #(
    parameter int TICK_W = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              active,
    input  logic [TICK_W-1:0] load_val,
    output logic              done
);
    logic [TICK_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_val == '0) ? TICK_W'(1) : load_val;
        end else if (active && cnt != '0) begin
            cnt <= cnt - TICK_W'(1);
        end
    end

    assign done = (cnt == TICK_W'(1));

    // a running line never sees an exhausted counter (R4)
    assert_cnt_live_R4: assert property (@(posedge clk) disable iff (rst)
        active |-> cnt != '0);

endmodule

// File: rtl/fls_payload.sv
module fls_payload
    import fls_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [WORD_W-1:0] word_in,
    input  logic [KIND_W-1:0] kind_in,
    output logic              valid_o,
    output logic [WORD_W-1:0] word_o,
    output logic [KIND_W-1:0] kind_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            word_o  <= '0;
            kind_o  <= '0;
        end else begin
            valid_o <= fire;
            if (fire) begin
                word_o <= word_in;
                kind_o <= kind_in;
            end
        end
    end
endmodule

// File: rtl/fls_ctrl.sv
module fls_ctrl
    import fls_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int FRAME_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [FRAME_W-1:0] frame_sel,
    input  logic               trigger,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic               timer_done,
    output logic [ADDR_W-1:0]  mem_addr,
    output seq_state_e         state_o,
    output line_hdr_t          hdr_o,
    output logic [WORD_W-1:0]  dur_o,
    output logic               load_o,
    output logic               fire_o,
    output logic               phase_clr_o
);
    seq_state_e        state, nxt;
    line_hdr_t         hdr_q;
    logic [WORD_W-1:0] dur_q;
    logic [ADDR_W-1:0] ptr;
    logic [LEN_W-1:0]  left;
    logic              clr_q;
    logic              entry_zero;

    assign entry_zero = (mem_rdata == '0);

    always_comb begin
        mem_addr = (state == ST_TABLE) ? ADDR_W'(frame_sel) : ptr;
        nxt      = state;
        load_o   = 1'b0;
        fire_o   = 1'b0;
        unique case (state)
            ST_TABLE: if (!entry_zero) nxt = ST_HEAD;
            ST_HEAD:  nxt = ST_DUR;
            ST_DUR:   nxt = (hdr_q.len != '0) ? ST_DATA : ST_ARM;
            ST_DATA: begin
                fire_o = 1'b1;
                if (left == LEN_W'(1)) nxt = ST_ARM;
            end
            ST_ARM: begin
                if (!hdr_q.trig_before || trigger) begin
                    nxt    = ST_RUN;
                    load_o = 1'b1;
                end
            end
            ST_RUN: begin
                if (timer_done) begin
                    if (hdr_q.wait_after)        nxt = ST_HOLD;
                    else if (line_follows(hdr_q)) nxt = ST_HEAD;
                    else                          nxt = ST_TABLE;
                end
            end
            ST_HOLD: begin
                if (trigger) nxt = line_follows(hdr_q) ? ST_HEAD : ST_TABLE;
            end
            default: nxt = ST_TABLE;
        endcase
        if (!enable) begin
            nxt    = ST_TABLE;
            load_o = 1'b0;
            fire_o = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_TABLE;
            hdr_q <= '0;
            dur_q <= '0;
            ptr   <= '0;
            left  <= '0;
            clr_q <= 1'b0;
        end else begin
            state <= nxt;
            clr_q <= load_o && hdr_q.clear;
            if (enable) begin
                unique case (state)
                    ST_TABLE: if (!entry_zero) ptr <= mem_rdata[ADDR_W-1:0];
                    ST_HEAD: begin
                        hdr_q <= unpack_hdr(mem_rdata);
                        left  <= unpack_hdr(mem_rdata).len;
                        ptr   <= ptr + ADDR_W'(1);
                    end
                    ST_DUR: begin
                        dur_q <= mem_rdata;
                        ptr   <= ptr + ADDR_W'(1);
                    end
                    ST_DATA: begin
                        left <= left - LEN_W'(1);
                        ptr  <= ptr + ADDR_W'(1);
                    end
                    default: ;
                endcase
            end
        end
    end

    assign state_o     = state;
    assign hdr_o       = hdr_q;
    assign dur_o       = dur_q;
    assign phase_clr_o = clr_q;

    // zero entry keeps the parser on the lookup area (R2)
    assert_park_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TABLE && enable && mem_rdata == '0) |=> state == ST_TABLE);

    // trigger-before line holds without trigger (R5)
    assert_trig_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARM && enable && hdr_q.trig_before && !trigger) |=> state == ST_ARM);

    // wait-after hold persists without trigger (R6)
    assert_wait_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && enable && !trigger) |=> state == ST_HOLD);

    // jump line ends at the lookup area (R7)
    assert_jump_back_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && enable && timer_done && hdr_q.jump && !hdr_q.wait_after)
        |=> state == ST_TABLE);

endmodule

// File: rtl/frame_line_seq.sv
module frame_line_seq
    import fls_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int FRAME_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [FRAME_W-1:0] frame_sel,
    input  logic               trigger,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [15:0]        mem_rdata,
    output logic               pay_valid,
    output logic [15:0]        pay_word,
    output logic [1:0]         pay_type,
    output logic               line_active,
    output logic               line_aux,
    output logic               line_silence,
    output logic [1:0]         line_type,
    output logic               phase_clr
);
    localparam int MAX_SHIFT = (1 << SHIFT_W) - 1;
    localparam int TICK_W    = WORD_W + MAX_SHIFT;

    seq_state_e        state;
    line_hdr_t         hdr;
    logic [WORD_W-1:0] dur;
    logic              load, fire, done;
    logic [TICK_W-1:0] tick_val;

    fls_ctrl #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .frame_sel  (frame_sel),
        .trigger    (trigger),
        .mem_rdata  (mem_rdata),
        .timer_done (done),
        .mem_addr   (mem_addr),
        .state_o    (state),
        .hdr_o      (hdr),
        .dur_o      (dur),
        .load_o     (load),
        .fire_o     (fire),
        .phase_clr_o(phase_clr)
    );

    assign tick_val = TICK_W'(dur) << hdr.shift;

    fls_timer #(.TICK_W(TICK_W)) timer_i (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .active  (state == ST_RUN),
        .load_val(tick_val),
        .done    (done)
    );

    fls_payload pay_i (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .word_in(mem_rdata),
        .kind_in(hdr.kind),
        .valid_o(pay_valid),
        .word_o (pay_word),
        .kind_o (pay_type)
    );

    always_comb begin
        line_active  = (state == ST_RUN);
        line_aux     = line_active && hdr.aux;
        line_silence = line_active && hdr.silence;
        line_type    = line_active ? hdr.kind : '0;
    end

    // clear pulse only within an active line (R8)
    assert_clr_in_line_R8: assert property (@(posedge clk) disable iff (rst)
        phase_clr |-> line_active);

    // payload is delivered before the line runs (R3)
    assert_pay_before_R3: assert property (@(posedge clk) disable iff (rst)
        pay_valid |-> !line_active);

    // disabled sequencer goes quiet (R10)
    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!line_active && !pay_valid));

endmodule

// File: tb/frame_line_seq_tb_top.sv
`timescale 1ns/1ps
module frame_line_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [2:0]  frame_sel = '0;
    logic        trigger = 1'b0;
    logic [9:0]  mem_addr;
    logic [15:0] mem_rdata;
    logic        pay_valid;
    logic [15:0] pay_word;
    logic [1:0]  pay_type;
    logic        line_active, line_aux, line_silence, phase_clr;
    logic [1:0]  line_type;

    logic [15:0] mem [0:63];
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign mem_rdata = (mem_addr < 10'd64) ? mem[mem_addr[5:0]] : 16'h0;

    frame_line_seq dut_i (
        .clk(clk), .rst(rst), .enable(enable), .frame_sel(frame_sel),
        .trigger(trigger), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .pay_valid(pay_valid), .pay_word(pay_word), .pay_type(pay_type),
        .line_active(line_active), .line_aux(line_aux),
        .line_silence(line_silence), .line_type(line_type),
        .phase_clr(phase_clr)
    );

    function automatic logic [15:0] hw(int len, int typ, bit trg, bit sil, bit aux,
                                       bit jmp, bit clr, bit wt, int sh);
        return {sh[3:0], wt, clr, jmp, aux, sil, trg, typ[1:0], len[3:0]};
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000 && !finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
        end
    end

    // waits for the next line; len=0 if none within gap_lim cycles
    task automatic grab_line(input int gap_lim, output int len, output int aux,
                             output int sil, output int typ, output int clr,
                             output int npay, output int psum, output int leak);
        int gap = 0;
        len = 0; aux = 0; sil = 0; typ = 0; clr = 0; npay = 0; psum = 0; leak = 0;
        while (!line_active && gap < gap_lim) begin
            if (pay_valid) begin
                npay++;
                psum += int'(pay_word);
                if (npay == 1) typ = int'(pay_type);
            end
            if (line_aux || line_silence || line_type != 0 || phase_clr) leak = 1;
            @(negedge clk);
            gap++;
        end
        if (line_active) begin
            aux = int'(line_aux);
            sil = int'(line_silence);
            typ = int'(line_type);
            clr = int'(phase_clr);
            while (line_active) begin
                if (len > 0 && phase_clr) clr = 9;
                len++;
                @(negedge clk);
            end
        end
    endtask

    // frame, len, aux, sil, type, npay, psum, clr
    localparam int VEC [0:2][0:7] = '{
        '{1, 5,  1, 0, 1, 2, 'h3333, 0},
        '{2, 12, 0, 1, 2, 1, 'h00AB, 0},
        '{5, 1,  0, 0, 0, 0, 0,      0}
    };

    initial begin
        int len, aux, sil, typ, clr, npay, psum, leak;
        for (int i = 0; i < 64; i++) mem[i] = 16'h0;
        mem[1] = 16'd8;  mem[2] = 16'd14; mem[3] = 16'd17;
        mem[4] = 16'd19; mem[5] = 16'd23;
        mem[8]  = hw(2, 1, 0, 0, 1, 0, 0, 0, 0); mem[9]  = 16'd5;
        mem[10] = 16'h1111; mem[11] = 16'h2222;
        mem[12] = hw(0, 0, 0, 0, 0, 1, 0, 0, 1); mem[13] = 16'd3;
        mem[14] = hw(1, 2, 0, 1, 0, 1, 0, 0, 2); mem[15] = 16'd3;
        mem[16] = 16'h00AB;
        mem[17] = hw(0, 3, 1, 0, 0, 1, 1, 0, 0); mem[18] = 16'd4;
        mem[19] = hw(0, 1, 0, 0, 0, 0, 0, 1, 0); mem[20] = 16'd2;
        mem[21] = hw(0, 2, 0, 0, 0, 1, 0, 0, 0); mem[22] = 16'd7;
        mem[23] = hw(0, 0, 0, 0, 0, 1, 0, 0, 0); mem[24] = 16'd0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!line_active && !pay_valid && !phase_clr, "R11", int'(line_active), 0);
        chk(mem_addr == 10'd0, "R11", int'(mem_addr), 0);

        // R3 R4 R9 vector walk
        for (int v = 0; v < 3; v++) begin
            enable = 1'b0;
            repeat (2) @(negedge clk);
            frame_sel = 3'(VEC[v][0]);
            enable = 1'b1;
            grab_line(60, len, aux, sil, typ, clr, npay, psum, leak);
            chk(len == VEC[v][1], "R4", len, VEC[v][1]);
            chk(aux == VEC[v][2], "R9", aux, VEC[v][2]);
            chk(sil == VEC[v][3], "R9", sil, VEC[v][3]);
            chk(typ == VEC[v][4], "R9", typ, VEC[v][4]);
            chk(npay == VEC[v][5], "R3", npay, VEC[v][5]);
            chk(psum == VEC[v][6], "R3", psum, VEC[v][6]);
            chk(clr == VEC[v][7], "R8", clr, VEC[v][7]);
            chk(leak == 0, "R9", leak, 0);
        end

        // R7 chaining then jump back through the lookup area
        enable = 1'b0;
        repeat (2) @(negedge clk);
        frame_sel = 3'd1;
        enable = 1'b1;
        grab_line(60, len, aux, sil, typ, clr, npay, psum, leak);
        grab_line(60, len, aux, sil, typ, clr, npay, psum, leak);
        chk(len == 6, "R7", len, 6);
        chk(npay == 0 && aux == 0, "R7", npay, 0);
        grab_line(60, len, aux, sil, typ, clr, npay, psum, leak);
        chk(len == 5 && aux == 1, "R7", len, 5);
        chk(psum == 'h3333, "R7", psum, 'h3333);

        // R2 parking on a zero entry, R1 address, leaving on reselect
        enable = 1'b0;
        repeat (2) @(negedge clk);
        frame_sel = 3'd6;
        enable = 1'b1;
        grab_line(50, len, aux, sil, typ, clr, npay, psum, leak);
        chk(len == 0 && npay == 0, "R2", len, 0);
        chk(mem_addr == 10'd6, "R1", int'(mem_addr), 6);
        frame_sel = 3'd2;
        grab_line(60, len, aux, sil, typ, clr, npay, psum, leak);
        chk(len == 12, "R2", len, 12);

        // R5 trigger-before, with R8 clear pulse
        enable = 1'b0;
        repeat (2) @(negedge clk);
        frame_sel = 3'd3;
        enable = 1'b1;
        grab_line(40, len, aux, sil, typ, clr, npay, psum, leak);
        chk(len == 0, "R5", len, 0);
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        grab_line(10, len, aux, sil, typ, clr, npay, psum, leak);
        chk(len == 4, "R5", len, 4);
        chk(typ == 3, "R9", typ, 3);
        chk(clr == 1, "R8", clr, 1);

        // R6 wait-after between two lines of one segment
        enable = 1'b0;
        repeat (2) @(negedge clk);
        frame_sel = 3'd4;
        enable = 1'b1;
        grab_line(60, len, aux, sil, typ, clr, npay, psum, leak);
        chk(len == 2, "R6", len, 2);
        grab_line(40, len, aux, sil, typ, clr, npay, psum, leak);
        chk(len == 0, "R6", len, 0);
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        grab_line(20, len, aux, sil, typ, clr, npay, psum, leak);
        chk(len == 7 && typ == 2, "R6", len, 7);

        // R10 enable dropped mid-line
        enable = 1'b0;
        repeat (2) @(negedge clk);
        frame_sel = 3'd2;
        enable = 1'b1;
        while (!line_active) @(negedge clk);
        repeat (4) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(!line_active, "R10", int'(line_active), 0);
        chk(mem_addr == 10'd2, "R10", int'(mem_addr), 2);
        grab_line(30, len, aux, sil, typ, clr, npay, psum, leak);
        chk(len == 0 && npay == 0, "R10", len, 0);

        summary();
    end

endmodule